// File: doc/BRIEF.md
# Per-Task Pointer Address Generator

This block turns a per-task pointer register into a memory address for a small core that interleaves several hardware tasks. Each task owns two pointers, and no task can see or disturb another task's pair. A request names a task, one of its two pointers, an addressing mode, a signed 6-bit index and an access size. The block returns the effective address and, for the updating modes, the new pointer value. That new value is committed to the pointer bank on the next clock edge.

The modes cover several kinds of access. A plain access uses the pointer as it is. A scaled-index access adds the index times the access size. Four modes step the pointer before or after the access. Two fixed 4-byte stack modes serve call and return: the push writes at the pointer and then increments it, and the pop decrements the pointer first and then reads. A separate inversion flag presents the bitwise inverse of the computed address, so a stack can grow down from the top of the address space. Software-style loads of a pointer (set) and reads of a pointer (get) use their own small ports.

Top module: `ptr_agen`

## Requirements
- R1: Synchronous reset clears every pointer of every task to zero.
- R2: An update or set aimed at one task's pointer leaves every other pointer, including the other pointer of the same task, unchanged.
- R3: Mode 1 (index) gives ea = pointer + sign-extended index × 2^size. Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. The mode asserts no write-back.
- R4: Modes 2 (post-increment) and 3 (post-decrement) give ea = pointer and write back the pointer plus or minus one access size.
- R5: Modes 4 (pre-increment) and 5 (pre-decrement) write back the pointer plus or minus one access size, and ea equals that new value.
- R6: Mode 6 (push) gives ea = pointer and writes back pointer + 4. Mode 7 (pop) writes back pointer − 4 and uses that value as ea. Both ignore the size field.
- R7: With req_inv high, ea is the bitwise inverse of the address that the mode would otherwise produce. The write-back value is not inverted.
- R8: A set request loads set_value into the selected pointer at the next edge. The get port then reads that pointer back combinationally. The pointer is addressed as {task, sel}, with sel 0 selecting the first pointer of the pair.
- R9: When a write-back and a set target the same pointer in the same cycle, the write-back value is stored and the set is lost.
- R10: Pointer arithmetic wraps modulo 2^AW.
- R11: Mode 0 (plain) gives ea = pointer with no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address request present |
| req_task | input | TW | Task issuing the request |
| req_sel | input | 1 | Which of the task's two pointers |
| req_mode | input | 3 | Addressing mode code 0..7 |
| req_index | input | 6 | Signed index for mode 1 |
| req_size | input | 2 | Access size as log2 of bytes |
| req_inv | input | 1 | Present inverted address |
| set_valid | input | 1 | Load a pointer |
| set_task | input | TW | Task of pointer to load |
| set_sel | input | 1 | Pointer of the pair to load |
| set_value | input | AW | Value to load |
| get_task | input | TW | Task of pointer to read |
| get_sel | input | 1 | Pointer of the pair to read |
| get_value | output | AW | Current value of the read pointer |
| ea | output | AW | Effective address |
| wb_valid | output | 1 | Pointer write-back happens this cycle |
| wb_value | output | AW | Updated pointer value |

## Verification
The effective address, wb_valid and wb_value are combinational in the current request and the stored pointer, so they are due in the same cycle. The bench drives each request on a falling edge and samples one nanosecond later, before the rising edge commits it. A write-back or set becomes visible at get_value only after the next rising edge, so every read-back check is taken on the falling edge that follows that commit edge. A check of the pointer bank is never made in the same cycle as the request that changes it.

// File: rtl/ptr_agen_pkg.sv
package ptr_agen_pkg;

    typedef enum logic [2:0] {
        MODE_PLAIN    = 3'd0,
        MODE_INDEX    = 3'd1,
        MODE_POST_INC = 3'd2,
        MODE_POST_DEC = 3'd3,
        MODE_PRE_INC  = 3'd4,
        MODE_PRE_DEC  = 3'd5,
        MODE_PUSH     = 3'd6,
        MODE_POP      = 3'd7
    } ptr_mode_e;

    // Fixed width of a return-address slot on a stack, as a shift amount
    localparam logic [1:0] STACK_SIZE_LOG2 = 2'd2;

    function automatic logic is_post(ptr_mode_e m);
        return (m == MODE_POST_INC) || (m == MODE_POST_DEC) || (m == MODE_PUSH);
    endfunction

    function automatic logic is_pre(ptr_mode_e m);
        return (m == MODE_PRE_INC) || (m == MODE_PRE_DEC) || (m == MODE_POP);
    endfunction

    function automatic logic is_down(ptr_mode_e m);
        return (m == MODE_POST_DEC) || (m == MODE_PRE_DEC) || (m == MODE_POP);
    endfunction

endpackage

// File: rtl/ptr_bank.sv
module ptr_bank #(
    parameter int NUM_PTRS = 8,
    parameter int AW       = 16,
    localparam int IW      = $clog2(NUM_PTRS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] cur_idx,
    output logic [AW-1:0] cur_val,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_val,
    input  logic          wb_en,
    input  logic [IW-1:0] wb_idx,
    input  logic [AW-1:0] wb_val,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic [AW-1:0] set_val
);
    logic [AW-1:0] ptr_q [NUM_PTRS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_PTRS; i++) begin
            if (rst)
                ptr_q[i] <= '0;
            else if (wb_en && wb_idx == IW'(i))
                ptr_q[i] <= wb_val;
            else if (set_en && set_idx == IW'(i))
                ptr_q[i] <= set_val;
        end
    end

    assign cur_val = ptr_q[cur_idx];
    assign rd_val  = ptr_q[rd_idx];

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (rd_val == '0 && cur_val == '0)); // R1

    AST_WB_BEATS_SET: assert property (@(posedge clk) disable iff (rst)
        (wb_en && set_en && wb_idx == set_idx) |=> ptr_q[$past(wb_idx)] == $past(wb_val)); // R9

    for (genvar g = 0; g < NUM_PTRS; g++) begin : g_iso
        AST_OTHERS_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!(wb_en && wb_idx == IW'(g)) && !(set_en && set_idx == IW'(g)))
            |=> $stable(ptr_q[g])); // R2
    end

endmodule

// File: rtl/ptr_alu.sv
module ptr_alu
    import ptr_agen_pkg::*;
#(
    parameter int AW = 16
) (
    input  ptr_mode_e     mode,
    input  logic [1:0]    size,
    input  logic [5:0]    index,
    input  logic          inv,
    input  logic [AW-1:0] cur,
    output logic [AW-1:0] ea,
    output logic          wb_en,
    output logic [AW-1:0] wb_val
);
    logic [1:0]    shamt;
    logic [AW-1:0] step;
    logic [AW-1:0] scaled;
    logic [AW-1:0] moved;
    logic [AW-1:0] base_ea;

    always_comb begin
        shamt  = (mode == MODE_PUSH || mode == MODE_POP) ? STACK_SIZE_LOG2 : size;
        step   = {{(AW-1){1'b0}}, 1'b1} << shamt;
        scaled = {{(AW-6){index[5]}}, index} << size;
        moved  = is_down(mode) ? (cur - step) : (cur + step);

        unique case (mode)
            MODE_PLAIN: base_ea = cur;
            MODE_INDEX: base_ea = cur + scaled;
            default:    base_ea = is_pre(mode) ? moved : cur;
        endcase

        wb_en  = is_pre(mode) || is_post(mode);
        wb_val = moved;
        ea     = inv ? ~base_ea : base_ea;
    end

endmodule

// File: rtl/ptr_agen.sv
module ptr_agen
    import ptr_agen_pkg::*;
#(
    parameter int NUM_TASKS = 4,
    parameter int AW        = 16,
    localparam int TW       = $clog2(NUM_TASKS),
    localparam int NUM_PTRS = NUM_TASKS * 2,
    localparam int IW       = TW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [TW-1:0] req_task,
    input  logic          req_sel,
    input  logic [2:0]    req_mode,
    input  logic [5:0]    req_index,
    input  logic [1:0]    req_size,
    input  logic          req_inv,
    input  logic          set_valid,
    input  logic [TW-1:0] set_task,
    input  logic          set_sel,
    input  logic [AW-1:0] set_value,
    input  logic [TW-1:0] get_task,
    input  logic          get_sel,
    output logic [AW-1:0] get_value,
    output logic [AW-1:0] ea,
    output logic          wb_valid,
    output logic [AW-1:0] wb_value
);
    ptr_mode_e     mode;
    logic [AW-1:0] cur_ptr;
    logic          alu_wb;
    logic [IW-1:0] req_idx;

    assign mode    = ptr_mode_e'(req_mode);
    assign req_idx = {req_task, req_sel};

    ptr_bank #(.NUM_PTRS(NUM_PTRS), .AW(AW)) i_bank (
        .clk     (clk),
        .rst     (rst),
        .cur_idx (req_idx),
        .cur_val (cur_ptr),
        .rd_idx  ({get_task, get_sel}),
        .rd_val  (get_value),
        .wb_en   (wb_valid),
        .wb_idx  (req_idx),
        .wb_val  (wb_value),
        .set_en  (set_valid),
        .set_idx ({set_task, set_sel}),
        .set_val (set_value)
    );

    ptr_alu #(.AW(AW)) i_alu (
        .mode   (mode),
        .size   (req_size),
        .index  (req_index),
        .inv    (req_inv),
        .cur    (cur_ptr),
        .ea     (ea),
        .wb_en  (alu_wb),
        .wb_val (wb_value)
    );

    assign wb_valid = req_valid && alu_wb;

    AST_READ_NO_WB: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (mode == MODE_PLAIN || mode == MODE_INDEX)) |-> !wb_valid); // R11

    AST_POST_AT_PTR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_inv && is_post(mode)) |-> ea == cur_ptr); // R4

    AST_PRE_AT_NEW: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_inv && is_pre(mode)) |-> ea == wb_value); // R5

    AST_INV_PRE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_inv && is_pre(mode)) |-> ea == ~wb_value); // R7

    AST_WB_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && get_task == req_task && get_sel == req_sel)
        |=> ($stable(get_task) && $stable(get_sel)) -> get_value == $past(wb_value)); // R8

endmodule

// File: tb/test_ptr_agen.sv
module test_ptr_agen;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_task = '0;
    logic          req_sel = 1'b0;
    logic [2:0]    req_mode = '0;
    logic [5:0]    req_index = '0;
    logic [1:0]    req_size = '0;
    logic          req_inv = 1'b0;
    logic          set_valid = 1'b0;
    logic [1:0]    set_task = '0;
    logic          set_sel = 1'b0;
    logic [AW-1:0] set_value = '0;
    logic [1:0]    get_task = '0;
    logic          get_sel = 1'b0;
    logic [AW-1:0] get_value, ea, wb_value;
    logic          wb_valid;

    int n_vec = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ptr_agen #(.NUM_TASKS(4), .AW(AW)) i_ptr_agen (.*);

    typedef struct packed {
        logic        do_set;
        logic [15:0] set_v;
        logic [1:0]  tsk;
        logic        sel;
        logic [2:0]  mode;
        logic [5:0]  idx;
        logic [1:0]  sz;
        logic        inv;
        logic [15:0] ea;
        logic        wbv;
        logic [15:0] wb;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 16'h1000, 2'd0, 1'b0, 3'd0, 6'h00, 2'd2, 1'b0, 16'h1000, 1'b0, 16'h0000, 8'd11}, // R11
        '{1'b0, 16'h0000, 2'd0, 1'b0, 3'd1, 6'h3D, 2'd2, 1'b0, 16'h0FF4, 1'b0, 16'h0000, 8'd3},  // R3
        '{1'b0, 16'h0000, 2'd0, 1'b0, 3'd1, 6'h1F, 2'd1, 1'b0, 16'h103E, 1'b0, 16'h0000, 8'd3},  // R3
        '{1'b0, 16'h0000, 2'd0, 1'b0, 3'd1, 6'h20, 2'd0, 1'b0, 16'h0FE0, 1'b0, 16'h0000, 8'd3},  // R3
        '{1'b0, 16'h0000, 2'd0, 1'b0, 3'd3, 6'h00, 2'd2, 1'b0, 16'h1000, 1'b1, 16'h0FFC, 8'd4},  // R4
        '{1'b0, 16'h0000, 2'd0, 1'b0, 3'd2, 6'h00, 2'd1, 1'b0, 16'h0FFC, 1'b1, 16'h0FFE, 8'd4},  // R4
        '{1'b0, 16'h0000, 2'd0, 1'b0, 3'd4, 6'h00, 2'd0, 1'b0, 16'h0FFF, 1'b1, 16'h0FFF, 8'd5},  // R5
        '{1'b0, 16'h0000, 2'd0, 1'b0, 3'd5, 6'h00, 2'd2, 1'b0, 16'h0FFB, 1'b1, 16'h0FFB, 8'd5},  // R5
        '{1'b0, 16'h0000, 2'd0, 1'b0, 3'd6, 6'h00, 2'd0, 1'b0, 16'h0FFB, 1'b1, 16'h0FFF, 8'd6},  // R6
        '{1'b0, 16'h0000, 2'd0, 1'b0, 3'd7, 6'h00, 2'd0, 1'b0, 16'h0FFB, 1'b1, 16'h0FFB, 8'd6},  // R6
        '{1'b1, 16'h0000, 2'd1, 1'b1, 3'd7, 6'h00, 2'd2, 1'b0, 16'hFFFC, 1'b1, 16'hFFFC, 8'd10}, // R10
        '{1'b0, 16'h0000, 2'd1, 1'b1, 3'd6, 6'h00, 2'd2, 1'b0, 16'hFFFC, 1'b1, 16'h0000, 8'd10}, // R10
        '{1'b1, 16'h0000, 2'd2, 1'b0, 3'd6, 6'h00, 2'd2, 1'b1, 16'hFFFF, 1'b1, 16'h0004, 8'd7},  // R7
        '{1'b0, 16'h0000, 2'd2, 1'b0, 3'd6, 6'h00, 2'd2, 1'b1, 16'hFFFB, 1'b1, 16'h0008, 8'd7},  // R7
        '{1'b0, 16'h0000, 2'd2, 1'b0, 3'd7, 6'h00, 2'd2, 1'b1, 16'hFFFB, 1'b1, 16'h0004, 8'd7},  // R7
        '{1'b0, 16'h0000, 2'd0, 1'b0, 3'd0, 6'h00, 2'd2, 1'b0, 16'h0FFB, 1'b0, 16'h0000, 8'd2},  // R2
        '{1'b1, 16'h0100, 2'd3, 1'b1, 3'd2, 6'h00, 2'd3, 1'b0, 16'h0100, 1'b1, 16'h0108, 8'd4}   // R4
    };

    task automatic check_get(input logic [1:0] t, input logic s, input logic [15:0] exp, input string rq);
        @(negedge clk);
        get_task = t;
        get_sel  = s;
        #1;
        n_vec++;
        if (get_value !== exp) begin
            n_fail++;
            $display("FAIL %s task%0d ptr%0d actual=%h expected=%h", rq, t, s, get_value, exp);
        end
    endtask

    task automatic do_set(input logic [1:0] t, input logic s, input logic [15:0] v);
        @(negedge clk);
        set_valid = 1'b1; set_task = t; set_sel = s; set_value = v;
        @(posedge clk);
        #0.5;
        set_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R0 actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5 rst = 1'b0;
        // R1: reset state of every pointer
        for (int k = 0; k < 8; k++) check_get(k[2:1], k[0], 16'h0000, "R1");

        for (int v = 0; v < NV; v++) begin
            if (VEC[v].do_set) do_set(VEC[v].tsk, VEC[v].sel, VEC[v].set_v);
            @(negedge clk);
            req_valid = 1'b1; req_task = VEC[v].tsk; req_sel = VEC[v].sel;
            req_mode = VEC[v].mode; req_index = VEC[v].idx; req_size = VEC[v].sz; req_inv = VEC[v].inv;
            #1;
            n_vec++;
            if (ea !== VEC[v].ea || wb_valid !== VEC[v].wbv || (VEC[v].wbv && wb_value !== VEC[v].wb)) begin
                n_fail++;
                $display("FAIL R%0d vec%0d actual ea=%h wbv=%b wb=%h expected ea=%h wbv=%b wb=%h",
                         VEC[v].rq, v, ea, wb_valid, wb_value, VEC[v].ea, VEC[v].wbv, VEC[v].wb);
            end
            @(posedge clk);
            #0.5 req_valid = 1'b0;
        end

        // R8: set value reads back through the get port
        check_get(2'd3, 1'b1, 16'h0108, "R8");
        check_get(2'd2, 1'b0, 16'h0004, "R8");

        // R9: write-back and set on the same pointer, write-back wins
        @(negedge clk);
        req_valid = 1'b1; req_task = 2'd0; req_sel = 1'b0; req_mode = 3'd2; req_size = 2'd2; req_inv = 1'b0;
        set_valid = 1'b1; set_task = 2'd0; set_sel = 1'b0; set_value = 16'h5555;
        @(posedge clk);
        #0.5 req_valid = 1'b0; set_valid = 1'b0;
        check_get(2'd0, 1'b0, 16'h0FFF, "R9");

        // R8 and R2: set on the sibling pointer while the first is pushed
        @(negedge clk);
        req_valid = 1'b1; req_task = 2'd0; req_sel = 1'b0; req_mode = 3'd6; req_size = 2'd0;
        set_valid = 1'b1; set_task = 2'd0; set_sel = 1'b1; set_value = 16'h2222;
        @(posedge clk);
        #0.5 req_valid = 1'b0; set_valid = 1'b0;
        check_get(2'd0, 1'b0, 16'h1003, "R2");
        check_get(2'd0, 1'b1, 16'h2222, "R8");
        check_get(2'd1, 1'b0, 16'h0000, "R2");
        check_get(2'd1, 1'b1, 16'h0000, "R2");

        // R1: reset mid-run clears everything again
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #0.5 rst = 1'b0;
        for (int k = 0; k < 8; k++) check_get(k[2:1], k[0], 16'h0000, "R1");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule